// File: doc/BRIEF.md
# Nested Reset Domain Generator

This block makes four active-low reset outputs for a small processor subsystem. The domains are nested. Debug logic is reset only by power-on. The system domain (peripherals plus the core side) is reset by power-on or by a system request. The core domain is reset by any of the three: power-on, a system request or a core-only request. A separate test-port reset feeds its own output and has no link to the other three domains. Requests are single-cycle pulses that come from a control register kept outside this block.

Each output goes low asynchronously when its reset input goes low. Each output comes back high only on a clock edge. The power-on input and the test-port input each pass through a release synchronizer. The system domain and the core domain each have a small state machine. This machine keeps its output low for a fixed stretch once its parent domain is running. The core machine treats the system output as its parent, so the core is always released after the system. A request that arrives while a domain is still held starts the stretch again from zero.

Each domain machine has three states. WAIT holds the output low while the parent is in reset. COUNT stretches the output low. RUN releases the output. The transitions are:
- start: WAIT to COUNT, taken when the parent is running.
- restart: COUNT to COUNT with the counter cleared, taken on a request.
- release: COUNT to RUN, taken when the counter reaches STRETCH-1.
- trip: RUN to COUNT, taken on a request.
- drop: COUNT or RUN to WAIT, taken when the parent falls.

Top module: `rstgen_top`

## Requirements
- R1: While `por_n_i` is low, `dbg_rst_n_o`, `sys_rst_n_o` and `core_rst_n_o` are low, and they go low without waiting for a clock edge.
- R2: After `por_n_i` rises, `dbg_rst_n_o` rises at the SYNC_STAGES-th rising clock edge.
- R3: After `por_n_i` rises, `sys_rst_n_o` rises at rising edge SYNC_STAGES+STRETCH+1. `core_rst_n_o` rises STRETCH+1 edges after that.
- R4: A `sys_req_i` pulse sampled at edge k drives `sys_rst_n_o` low after edge k and releases it after edge k+STRETCH. `dbg_rst_n_o` does not change.
- R5: The core domain is nested inside the system domain. `core_rst_n_o` is never high while `sys_rst_n_o` is low, and `sys_rst_n_o` is never high while `dbg_rst_n_o` is low. After a system request sampled at edge k, `core_rst_n_o` rises after edge k+2*STRETCH+1.
- R6: A `core_req_i` pulse sampled at edge k holds `core_rst_n_o` low from edge k through edge k+STRETCH-1. `sys_rst_n_o` and `dbg_rst_n_o` do not change.
- R7: A request that arrives while its own domain is still stretching restarts the stretch. The output then rises STRETCH edges after the last request.
- R8: `tap_rst_n_o` goes low as soon as `tap_trst_n_i` goes low, and rises at the SYNC_STAGES-th edge after it rises. Neither power-on nor the requests affect it.
- R9: Requests that arrive while `por_n_i` is low have no effect on the release timing in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all release timing |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| tap_trst_n_i | input | 1 | Test-port reset, active low, asynchronous |
| sys_req_i | input | 1 | Single-cycle system reset request |
| core_req_i | input | 1 | Single-cycle core-only reset request |
| dbg_rst_n_o | output | 1 | Debug domain reset, active low |
| sys_rst_n_o | output | 1 | System domain reset, active low |
| core_rst_n_o | output | 1 | Core domain reset, active low |
| tap_rst_n_o | output | 1 | Test-port reset, active low |

## Verification
The bench uses the default values STRETCH=16 and SYNC_STAGES=2. With these values each release count is short enough to measure exactly, cycle by cycle. The bench sweeps the gap between a first request and a second one over every offset inside the stretch window and a few offsets past it, for both request kinds. It also sweeps a core request placed at every point of a running system stretch. This covers each restart point and each point where the core machine enters WAIT.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    // State of one stretched reset domain
    typedef enum logic [1:0] {
        DOM_WAIT  = 2'd0,   // parent domain still in reset
        DOM_COUNT = 2'd1,   // stretching the reset low
        DOM_RUN   = 2'd2    // reset released
    } dom_state_e;

endpackage

// File: rtl/rstgen_sync.sv
// Release synchronizer: clears at once, releases after STAGES clock edges.
module rstgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic rel_n_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rel_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstgen_domain.sv
// One nested reset domain with a restartable stretch counter.
module rstgen_domain
    import rstgen_pkg::*;
#(
    parameter int STRETCH = 16
) (
    input  logic clk_i,
    input  logic arst_n_i,
    input  logic enable_i,
    input  logic req_i,
    output logic rst_n_o
);

    localparam int              CW   = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [CW-1:0]   LAST = CW'(STRETCH - 1);

    dom_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            state_q <= DOM_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DOM_WAIT: begin
                if (enable_i) begin            // start
                    state_d = DOM_COUNT;
                    cnt_d   = '0;
                end
            end
            DOM_COUNT: begin
                if (!enable_i) begin           // drop
                    state_d = DOM_WAIT;
                    cnt_d   = '0;
                end else if (req_i) begin      // restart
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin  // release
                    state_d = DOM_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            DOM_RUN: begin
                if (!enable_i) begin           // drop
                    state_d = DOM_WAIT;
                end else if (req_i) begin      // trip
                    state_d = DOM_COUNT;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = DOM_WAIT;
                cnt_d   = '0;
            end
        endcase
    end

    // Output register, aligned with the state register
    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            rst_n_o <= 1'b0;
        end else begin
            rst_n_o <= (state_d == DOM_RUN);
        end
    end

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
    parameter int STRETCH     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic tap_trst_n_i,
    input  logic sys_req_i,
    input  logic core_req_i,
    output logic dbg_rst_n_o,
    output logic sys_rst_n_o,
    output logic core_rst_n_o,
    output logic tap_rst_n_o
);

    // Domain 0 is the system domain, domain 1 is the core domain nested in it
    localparam int N_DOM = 2;

    logic               por_ok_n;
    logic               tap_ok_n;
    logic [N_DOM-1:0]   dom_req;
    logic [N_DOM-1:0]   dom_en;
    logic [N_DOM-1:0]   dom_rst_n;

    rstgen_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
        .clk_i    (clk_i),
        .arst_n_i (por_n_i),
        .rel_n_o  (por_ok_n)
    );

    rstgen_sync #(.STAGES(SYNC_STAGES)) u_tap_sync (
        .clk_i    (clk_i),
        .arst_n_i (tap_trst_n_i),
        .rel_n_o  (tap_ok_n)
    );

    // A system request also resets the core
    assign dom_req[0] = sys_req_i;
    assign dom_req[1] = sys_req_i | core_req_i;

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        if (g == 0) begin : g_root
            assign dom_en[g] = por_ok_n;
        end else begin : g_child
            assign dom_en[g] = dom_rst_n[g-1];
        end

        rstgen_domain #(.STRETCH(STRETCH)) u_dom (
            .clk_i    (clk_i),
            .arst_n_i (por_n_i),
            .enable_i (dom_en[g]),
            .req_i    (dom_req[g]),
            .rst_n_o  (dom_rst_n[g])
        );
    end

    assign dbg_rst_n_o  = por_ok_n;
    assign sys_rst_n_o  = dom_rst_n[0];
    assign core_rst_n_o = dom_rst_n[1];
    assign tap_rst_n_o  = tap_ok_n;

endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk #(
    parameter int STRETCH = 16
) (
    input logic clk_i,
    input logic por_n_i,
    input logic sys_req_i,
    input logic core_req_i,
    input logic dbg_rst_n_o,
    input logic sys_rst_n_o,
    input logic core_rst_n_o
);

    localparam int LW = $clog2(STRETCH + 1) + 1;

    logic [LW-1:0] sys_low_cnt;

    // Counts the cycles sys reset has been low, saturating at STRETCH
    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            sys_low_cnt <= '0;
        end else if (sys_rst_n_o) begin
            sys_low_cnt <= '0;
        end else if (sys_low_cnt < LW'(STRETCH)) begin
            sys_low_cnt <= sys_low_cnt + 1'b1;
        end
    end

    // R1
    always_ff @(negedge clk_i) begin
        if (!por_n_i) begin
            por_all_low_chk: assert (!dbg_rst_n_o && !sys_rst_n_o && !core_rst_n_o);
        end
    end

    // R4
    sys_req_trip_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        sys_req_i |=> !sys_rst_n_o);

    // R4
    dbg_spared_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        dbg_rst_n_o |=> dbg_rst_n_o);

    // R4
    sys_stretch_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(sys_rst_n_o) |-> (sys_low_cnt >= LW'(STRETCH)));

    // R5
    nest_core_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        core_rst_n_o |-> sys_rst_n_o);

    // R5
    nest_sys_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        sys_rst_n_o |-> dbg_rst_n_o);

    // R6
    core_req_trip_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        core_req_i |=> !core_rst_n_o);

    // R6
    core_spares_sys_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (core_req_i && !sys_req_i && sys_rst_n_o) |=> sys_rst_n_o);

endmodule

bind rstgen_top rstgen_chk #(.STRETCH(STRETCH)) u_chk (
    .clk_i        (clk_i),
    .por_n_i      (por_n_i),
    .sys_req_i    (sys_req_i),
    .core_req_i   (core_req_i),
    .dbg_rst_n_o  (dbg_rst_n_o),
    .sys_rst_n_o  (sys_rst_n_o),
    .core_rst_n_o (core_rst_n_o)
);

// File: tb/rstgen_top_tb_top.sv
module rstgen_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int STRETCH = 16;
    localparam int SYNC    = 2;
    localparam int WIN     = 80;

    logic clk = 1'b0;
    logic por_n, tap_n, sys_req, core_req;
    logic dbg_rst_n, sys_rst_n, core_rst_n, tap_rst_n;
    int   n_cmp = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    rstgen_top #(.STRETCH(STRETCH), .SYNC_STAGES(SYNC)) dut_i (
        .clk_i        (clk),
        .por_n_i      (por_n),
        .tap_trst_n_i (tap_n),
        .sys_req_i    (sys_req),
        .core_req_i   (core_req),
        .dbg_rst_n_o  (dbg_rst_n),
        .sys_rst_n_o  (sys_rst_n),
        .core_rst_n_o (core_rst_n),
        .tap_rst_n_o  (tap_rst_n)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Counts low samples of each output, starting at the current negedge
    task automatic watch(output int s, output int c, output int d, output int t);
        s = 0; c = 0; d = 0; t = 0;
        for (int i = 0; i < WIN; i++) begin
            if (!sys_rst_n)  s++;
            if (!core_rst_n) c++;
            if (!dbg_rst_n)  d++;
            if (!tap_rst_n)  t++;
            @(negedge clk);
        end
    endtask

    // Called at a negedge; the request is sampled at the next posedge
    task automatic pulse_sys();
        sys_req = 1'b1;
        @(negedge clk);
        sys_req = 1'b0;
    endtask

    task automatic pulse_core();
        core_req = 1'b1;
        @(negedge clk);
        core_req = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s, c, d, t;
        por_n = 1'b0; tap_n = 1'b0; sys_req = 1'b0; core_req = 1'b0;
        @(negedge clk);
        // R1 R8 reset state
        chk("R1 dbg at reset",  int'(dbg_rst_n),  0);
        chk("R1 sys at reset",  int'(sys_rst_n),  0);
        chk("R1 core at reset", int'(core_rst_n), 0);
        chk("R8 tap at reset",  int'(tap_rst_n),  0);

        // R8 test-port release while power-on is still low
        tap_n = 1'b1;
        watch(s, c, d, t);
        chk("R8 tap release lows", t, SYNC);
        chk("R1 sys held by por", s, WIN);

        // R9 requests during power-on are ignored; R2 R3 release timing
        pulse_sys();
        pulse_core();
        por_n = 1'b1;
        watch(s, c, d, t);
        chk("R2 dbg release lows", d, SYNC);
        chk("R3 sys release lows", s, SYNC + STRETCH + 1);
        chk("R3 core release lows", c, SYNC + 2 * STRETCH + 2);
        chk("R8 tap untouched by por", t, 0);

        // R4 R5 single system request
        pulse_sys();
        watch(s, c, d, t);
        chk("R4 sys stretch", s, STRETCH);
        chk("R5 core after sys", c, 2 * STRETCH + 1);
        chk("R4 dbg spared", d, 0);
        chk("R8 tap spared by sys", t, 0);

        // R6 single core request
        pulse_core();
        watch(s, c, d, t);
        chk("R6 core stretch", c, STRETCH);
        chk("R6 sys spared", s, 0);
        chk("R6 dbg spared", d, 0);

        // R7 system restart sweep over every gap
        for (int gap = 1; gap <= STRETCH + 4; gap++) begin
            pulse_sys();
            repeat (gap - 1) @(negedge clk);
            pulse_sys();
            watch(s, c, d, t);
            chk($sformatf("R7 sys restart gap %0d", gap), s, STRETCH);
            chk($sformatf("R5 core restart gap %0d", gap), c, 2 * STRETCH + 1);
            chk($sformatf("R4 dbg gap %0d", gap), d, 0);
        end

        // R7 core restart sweep
        for (int gap = 1; gap <= STRETCH + 4; gap++) begin
            pulse_core();
            repeat (gap - 1) @(negedge clk);
            pulse_core();
            watch(s, c, d, t);
            chk($sformatf("R7 core restart gap %0d", gap), c, STRETCH);
            chk($sformatf("R6 sys spared gap %0d", gap), s, 0);
        end

        // R5 core request landing inside a system stretch
        for (int off = 1; off < STRETCH; off++) begin
            pulse_sys();
            repeat (off - 1) @(negedge clk);
            pulse_core();
            watch(s, c, d, t);
            chk($sformatf("R5 sys left off %0d", off), s, STRETCH - off);
            chk($sformatf("R5 core nested off %0d", off), c, 2 * STRETCH + 1 - off);
        end

        // R1 asynchronous power-on assertion mid-cycle, R8 tap unaffected
        @(posedge clk);
        #1 por_n = 1'b0;
        #0.5;
        chk("R1 async dbg", int'(dbg_rst_n), 0);
        chk("R1 async sys", int'(sys_rst_n), 0);
        chk("R1 async core", int'(core_rst_n), 0);
        chk("R8 tap during por", int'(tap_rst_n), 1);
        @(negedge clk);
        pulse_sys();
        pulse_core();
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        watch(s, c, d, t);
        chk("R9 dbg after reqs in por", d, SYNC);
        chk("R9 sys after reqs in por", s, SYNC + STRETCH + 1);
        chk("R9 core after reqs in por", c, SYNC + 2 * STRETCH + 2);

        // R8 asynchronous test-port reset, other domains unaffected
        @(posedge clk);
        #1 tap_n = 1'b0;
        #0.5;
        chk("R8 async tap", int'(tap_rst_n), 0);
        chk("R8 sys spared by tap", int'(sys_rst_n), 1);
        @(negedge clk);
        tap_n = 1'b1;
        watch(s, c, d, t);
        chk("R8 tap release", t, SYNC);
        chk("R8 core spared by tap", c, 0);
        chk("R8 dbg spared by tap", d, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule